// File: doc/BRIEF.md
# Synchronous SRAM Read Output Stage

This block is the read-return path of a synchronous burst memory. It holds a small behavioural storage array and hands read words back on a data bus with a separate drive-enable, so the surrounding pad logic can tri-state the bus. Every control input except the output enable is captured on the rising clock edge. A command cycle is either a start cycle, where the three chip enables and the address are sampled, or a continue cycle, which repeats the access type of the open session at the session's held address.

A static timing-mode input chooses how read data reaches the bus. With the mode low, the word read from the array goes straight to the bus in the cycle after the command edge. With the mode high, the word is first captured by an output register and appears one edge later. Deselects travel through the same stages as reads, so in registered mode a deselect leaves the bus driven for one more full cycle. A sleep request takes effect two edges after it is sampled. While asleep the block ignores commands and keeps its stored contents.

Boards should tie the mode input high when no choice is made; registered timing is the intended default. A parameter can also lock the mode at build time.

Top module: `sram_rd_out_stage`

## Requirements
- R1: After reset and before any read, `rd_vld` and `dq_oe` are 0.
- R2: With `pipe_mode` = 0, a read sampled at edge k gives `rd_vld` = 1 and `dq_o` = the stored word in the cycle after edge k.
- R3: With `pipe_mode` = 1, a read sampled at edge k is not yet valid after edge k. It is valid, with the stored word on `dq_o`, after edge k+1.
- R4: With `pipe_mode` = 1, after a read and then a deselect sampled at edge k, the bus stays driven after edge k and is released after edge k+1.
- R5: `oe_n` = 1 forces `dq_oe` to 0 within the same cycle, without a clock edge, while `rd_vld` keeps its value.
- R6: On a start cycle (`acc_start` = 1) the device is selected only when `ce1_n` = 0, `ce2` = 1 and `ce3_n` = 0. Any other combination is a deselect. On continue cycles the enables are ignored.
- R7: A continue cycle (`acc_start` = 0) repeats the open session's access at the address latched on its start cycle and ignores `addr`. After a deselecting start, continue cycles stay deselected.
- R8: A write cycle (`wr_n` = 0 while selected) never drives the bus. In registered mode, a read still waiting in the output register is dropped on the first write cycle.
- R9: A write stores `wdata` at the access address on its command edge, and a later read returns that word.
- R10: A sleep request sampled at edge k makes the block asleep after edge k+1. While asleep, `rd_vld` and `dq_oe` stay 0, commands (including writes) are ignored and stored data is kept. Normal operation resumes two edges after the request drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| pipe_mode | input | 1 | 1 = registered output timing, 0 = flow-through timing |
| sleep_req | input | 1 | Sleep request, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| acc_start | input | 1 | 1 = start cycle (sample enables and address), 0 = continue cycle |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | 0 = write access, 1 = read access |
| addr | input | ADDR_W | Word address, sampled on start cycles |
| wdata | input | DATA_W | Write word |
| dq_o | output | DATA_W | Data bus value |
| dq_oe | output | 1 | Bus drive enable; 0 = high impedance |
| rd_vld | output | 1 | Read data on `dq_o` is valid this cycle |

## Verification
The hardest state to reach is a read waiting in the output register at the moment the next command is a write, or a sleep boundary. In both cases the drive must be dropped even though the register holds good data. The stimulus first places a registered read in flight, then issues a write on the very next edge. Separately, it raises the sleep request on the same edge as a read and then tries a write while asleep. A later readback shows the write was discarded. The double-length release after a deselect is reached by following a registered read immediately with a deselect and sampling the bus on both of the following edges.

// File: rtl/sro_pkg.sv
package sro_pkg;

   // access type carried down the read pipeline
   typedef enum logic [1:0] {
      K_DES = 2'd0,
      K_RD  = 2'd1,
      K_WR  = 2'd2
   } acc_kind_e;

   // edges from sampling the sleep request to being asleep
   localparam int SLEEP_LAT = 2;

endpackage

// File: rtl/sro_sleep_ctl.sv
module sro_sleep_ctl
   import sro_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   output logic asleep,
   output logic sleep_soon
);

   logic [SLEEP_LAT-1:0] slp_sr;

   if (SLEEP_LAT != 2) begin : g_bad_lat
      $error("sro_sleep_ctl: SLEEP_LAT must be 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slp_sr <= '0;
      else        slp_sr <= {slp_sr[SLEEP_LAT-2:0], sleep_req};
   end

   assign sleep_soon = slp_sr[SLEEP_LAT-2];
   assign asleep     = slp_sr[SLEEP_LAT-1];

   // R10: entry two edges after the request, exit two edges after release
   p_sleep_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |=> ##1 asleep);
   p_sleep_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_req |=> ##1 !asleep);

endmodule

// File: rtl/sro_cmd_stage.sv
module sro_cmd_stage
   import sro_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_start,
   input  logic              ce1_n,
   input  logic              ce2,
   input  logic              ce3_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              asleep,
   output acc_kind_e         s1_kind,
   output logic [ADDR_W-1:0] s1_addr,
   output logic              wr_fire,
   output logic [ADDR_W-1:0] wr_addr
);

   logic              sess_sel;
   logic [ADDR_W-1:0] sess_addr;
   logic              dev_sel;
   logic              next_sel;
   logic [ADDR_W-1:0] next_addr;
   acc_kind_e         next_kind;

   // enables count only on start cycles; continue cycles reuse the session
   always_comb begin
      dev_sel   = !ce1_n && ce2 && !ce3_n;
      next_sel  = acc_start ? dev_sel : sess_sel;
      next_addr = acc_start ? addr : sess_addr;
      if (asleep)        next_kind = K_DES;
      else if (!next_sel) next_kind = K_DES;
      else if (wr_n)     next_kind = K_RD;
      else               next_kind = K_WR;
   end

   assign wr_fire = (next_kind == K_WR);
   assign wr_addr = next_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sess_sel  <= 1'b0;
         sess_addr <= '0;
         s1_kind   <= K_DES;
         s1_addr   <= '0;
      end else begin
         s1_kind <= next_kind;
         if (!asleep) begin
            sess_sel  <= next_sel;
            sess_addr <= next_addr;
            s1_addr   <= next_addr;
         end
      end
   end

   // R7: a continue cycle leaves the session address alone
   p_cont_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_start |=> $stable(sess_addr));
   // R6: enables on a continue cycle cannot change the selection
   p_cont_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_start |=> $stable(sess_sel));
   // R10: nothing enters the pipeline while asleep
   p_sleep_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |=> s1_kind == K_DES);

endmodule

// File: rtl/sro_mem_array.sv
module sro_mem_array #(
   parameter int DATA_W = 18,
   parameter int DEPTH  = 64,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] cells [DEPTH];

   if ((1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("sro_mem_array: DEPTH must equal 2**ADDR_W");
   end

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/sro_out_stage.sv
module sro_out_stage
   import sro_pkg::*;
#(
   parameter int DATA_W    = 18,
   parameter int MODE_LOCK = 0   // 0: pin selects, 1: always registered, 2: always flow-through
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_mode,
   input  acc_kind_e         s1_kind,
   input  logic [DATA_W-1:0] rdata,
   input  logic              asleep,
   input  logic              oe_n,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe,
   output logic              rd_vld
);

   logic              eff_pipe;
   logic              pipe_vld;
   logic [DATA_W-1:0] pipe_data;
   logic              flow_vld;
   logic              sel_vld;

   if (MODE_LOCK == 0) begin : g_mode_pin
      assign eff_pipe = pipe_mode;
   end else if (MODE_LOCK == 1) begin : g_mode_reg
      assign eff_pipe = 1'b1;
   end else begin : g_mode_flow
      assign eff_pipe = 1'b0;
   end

   if (MODE_LOCK != 2) begin : g_out_reg
      acc_kind_e         s2_kind;
      logic [DATA_W-1:0] s2_data;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s2_kind <= K_DES;
            s2_data <= '0;
         end else begin
            s2_kind <= asleep ? K_DES : s1_kind;
            if (s1_kind == K_RD) s2_data <= rdata;
         end
      end

      assign pipe_vld  = (s2_kind == K_RD);
      assign pipe_data = s2_data;
   end else begin : g_no_reg
      assign pipe_vld  = 1'b0;
      assign pipe_data = '0;
   end

   assign flow_vld = (s1_kind == K_RD);

   // a write in stage one drops a read waiting in the output register
   assign sel_vld = eff_pipe ? (pipe_vld && (s1_kind != K_WR)) : flow_vld;
   assign rd_vld  = sel_vld && !asleep;
   assign dq_o    = eff_pipe ? pipe_data : rdata;
   assign dq_oe   = rd_vld && !oe_n;

   // R3: a registered read shows up one edge after it enters stage one
   p_pipe_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eff_pipe && s1_kind == K_RD && !asleep
      |=> rd_vld || s1_kind == K_WR || asleep || !eff_pipe);
   // R4: a deselect behind a read keeps the bus driven one more cycle
   p_dcd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eff_pipe && s1_kind == K_RD && !asleep ##1 eff_pipe && s1_kind == K_DES && !asleep
      |-> rd_vld);
   // R4: and releases it once the deselect reaches the output register
   p_dcd_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eff_pipe && s1_kind == K_DES |=> !rd_vld || !eff_pipe);

endmodule

// File: rtl/sram_rd_out_stage.sv
module sram_rd_out_stage
   import sro_pkg::*;
#(
   parameter int DATA_W    = 18,
   parameter int DEPTH     = 64,
   parameter int MODE_LOCK = 0,
   localparam int ADDR_W   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_mode,
   input  logic              sleep_req,
   input  logic              oe_n,
   input  logic              acc_start,
   input  logic              ce1_n,
   input  logic              ce2,
   input  logic              ce3_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe,
   output logic              rd_vld
);

   localparam bit FLOW_ALLOWED = (MODE_LOCK != 1);

   if (DATA_W < 1 || DATA_W > 144) begin : g_bad_w
      $error("sram_rd_out_stage: DATA_W out of range");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_d
      $error("sram_rd_out_stage: DEPTH must be a power of two >= 2");
   end
   if (MODE_LOCK < 0 || MODE_LOCK > 2) begin : g_bad_m
      $error("sram_rd_out_stage: MODE_LOCK must be 0, 1 or 2");
   end

   logic              asleep;
   logic              sleep_soon;
   acc_kind_e         s1_kind;
   logic [ADDR_W-1:0] s1_addr;
   logic              wr_fire;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] rdata;

   sro_sleep_ctl u_sleep (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_req  (sleep_req),
      .asleep     (asleep),
      .sleep_soon (sleep_soon)
   );

   sro_cmd_stage #(.ADDR_W(ADDR_W)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_start (acc_start),
      .ce1_n     (ce1_n),
      .ce2       (ce2),
      .ce3_n     (ce3_n),
      .wr_n      (wr_n),
      .addr      (addr),
      .asleep    (asleep),
      .s1_kind   (s1_kind),
      .s1_addr   (s1_addr),
      .wr_fire   (wr_fire),
      .wr_addr   (wr_addr)
   );

   sro_mem_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
      .clk   (clk),
      .we    (wr_fire),
      .waddr (wr_addr),
      .wdata (wdata),
      .raddr (s1_addr),
      .rdata (rdata)
   );

   sro_out_stage #(.DATA_W(DATA_W), .MODE_LOCK(MODE_LOCK)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .pipe_mode (pipe_mode),
      .s1_kind   (s1_kind),
      .rdata     (rdata),
      .asleep    (asleep),
      .oe_n      (oe_n),
      .dq_o      (dq_o),
      .dq_oe     (dq_oe),
      .rd_vld    (rd_vld)
   );

   // R2: flow-through read is on the bus right after its command edge
   p_flow_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      MODE_LOCK != 1 && acc_start && !ce1_n && ce2 && !ce3_n && wr_n
      && (!pipe_mode || MODE_LOCK == 2) && !asleep && !sleep_soon
      |=> rd_vld || (pipe_mode && MODE_LOCK == 0));
   // R6: a start cycle without full enables gives no flow-through data
   p_desel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      FLOW_ALLOWED && acc_start && !(!ce1_n && ce2 && !ce3_n)
      && (!pipe_mode || MODE_LOCK == 2)
      |=> !rd_vld || (pipe_mode && MODE_LOCK == 0));
   // R8: a selected write cycle never drives the bus
   p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_start && !ce1_n && ce2 && !ce3_n && !wr_n && !asleep |=> !dq_oe);
   // R5: output enable wins over the pipeline at all times
   p_oe_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dq_oe);
   // R10: no valid data while asleep
   p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> !rd_vld && !dq_oe);

endmodule

// File: tb/sim_sram_rd_out_stage.sv
module sim_sram_rd_out_stage;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        pipe_mode;
   logic        sleep_req;
   logic        oe_n;
   logic        acc_start;
   logic        ce1_n;
   logic        ce2;
   logic        ce3_n;
   logic        wr_n;
   logic [5:0]  addr;
   logic [17:0] wdata;
   logic [17:0] dq_o;
   logic        dq_oe;
   logic        rd_vld;

   logic [17:0] refm [64];
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done  = 1'b0;

   always #5 clk = ~clk;

   sram_rd_out_stage u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .pipe_mode (pipe_mode),
      .sleep_req (sleep_req),
      .oe_n      (oe_n),
      .acc_start (acc_start),
      .ce1_n     (ce1_n),
      .ce2       (ce2),
      .ce3_n     (ce3_n),
      .wr_n      (wr_n),
      .addr      (addr),
      .wdata     (wdata),
      .dq_o      (dq_o),
      .dq_oe     (dq_oe),
      .rd_vld    (rd_vld)
   );

   function automatic logic [17:0] pat(input int a);
      return 18'((a * 18'h0A5) + 18'h111);
   endfunction

   task automatic expect_out(input string req, input logic ev, input logic [17:0] ed);
      n_chk++;
      if (rd_vld !== ev || dq_oe !== (ev & ~oe_n) || (ev && dq_o !== ed)) begin
         n_bad++;
         $display("FAIL %s: vld=%b oe=%b dq=%h expected vld=%b oe=%b dq=%h",
                  req, rd_vld, dq_oe, dq_o, ev, ev & ~oe_n, ed);
      end
   endtask

   // one command edge, then sample just after it
   task automatic cyc(input logic st, input logic c1n, input logic c2, input logic c3n,
                      input logic wn, input logic [5:0] a, input logic [17:0] d);
      @(negedge clk);
      acc_start = st; ce1_n = c1n; ce2 = c2; ce3_n = c3n;
      wr_n = wn; addr = a; wdata = d;
      @(posedge clk);
      #1;
   endtask

   task automatic rd(input logic [5:0] a);
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, a, 18'h0);
   endtask

   task automatic wr(input logic [5:0] a, input logic [17:0] d);
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, a, d);
      refm[a] = d;
   endtask

   task automatic des();
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 6'd0, 18'h0);
   endtask

   // continue cycle with deliberately bad enables and a stray address
   task automatic cont(input logic wn, input logic [17:0] d);
      cyc(1'b0, 1'b1, 1'b0, 1'b1, wn, 6'd9, d);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; pipe_mode = 1'b1; sleep_req = 1'b0; oe_n = 1'b0;
      acc_start = 1'b0; ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
      wr_n = 1'b1; addr = '0; wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      expect_out("R1 after reset", 1'b0, 18'h0);
      des();
      expect_out("R1 idle after reset", 1'b0, 18'h0);
   endtask

   task automatic t_fill();
      pipe_mode = 1'b0;
      des();
      for (int a = 0; a < 10; a++) begin
         wr(6'(a), pat(a));
         expect_out("R8 flow write quiet", 1'b0, 18'h0);
      end
   endtask

   task automatic t_flow();
      pipe_mode = 1'b0;
      des();
      rd(6'd3);
      expect_out("R2 flow read", 1'b1, refm[3]);
      rd(6'd7);
      expect_out("R2 flow back-to-back", 1'b1, refm[7]);
      des();
      expect_out("R2 flow release", 1'b0, 18'h0);
   endtask

   task automatic t_pipe();
      des(); pipe_mode = 1'b1; des(); des();
      rd(6'd5);
      expect_out("R3 not yet valid", 1'b0, 18'h0);
      des();
      expect_out("R3/R4 valid, held past deselect", 1'b1, refm[5]);
      des();
      expect_out("R4 released", 1'b0, 18'h0);
   endtask

   task automatic t_pipe_stream();
      pipe_mode = 1'b1;
      des();
      rd(6'd1);
      expect_out("R3 stream first", 1'b0, 18'h0);
      rd(6'd2);
      expect_out("R3 stream word1", 1'b1, refm[1]);
      rd(6'd3);
      expect_out("R3 stream word2", 1'b1, refm[2]);
      des();
      expect_out("R4 stream word3", 1'b1, refm[3]);
      des();
      expect_out("R4 stream release", 1'b0, 18'h0);
   endtask

   task automatic t_oe();
      pipe_mode = 1'b1;
      rd(6'd7);
      des();
      expect_out("R5 driven", 1'b1, refm[7]);
      oe_n = 1'b1;
      #1;
      expect_out("R5 async disable", 1'b1, refm[7]);
      oe_n = 1'b0;
      #1;
      expect_out("R5 async enable", 1'b1, refm[7]);
      des();
   endtask

   task automatic t_select();
      pipe_mode = 1'b0;
      des();
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'd3, 18'h0);
      expect_out("R6 ce2 low", 1'b0, 18'h0);
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 6'd3, 18'h0);
      expect_out("R6 ce1_n high", 1'b0, 18'h0);
      cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 6'd3, 18'h0);
      expect_out("R6 ce3_n high", 1'b0, 18'h0);
      rd(6'd4);
      expect_out("R6 full select", 1'b1, refm[4]);
      cont(1'b1, 18'h0);
      expect_out("R6/R7 continue ignores enables and addr", 1'b1, refm[4]);
   endtask

   task automatic t_continue();
      pipe_mode = 1'b0;
      des();
      cont(1'b1, 18'h0);
      expect_out("R7 continue after deselect", 1'b0, 18'h0);
      rd(6'd1);
      expect_out("R7 session read", 1'b1, refm[1]);
      cont(1'b0, 18'h2AAAA);
      refm[1] = 18'h2AAAA;
      expect_out("R8 continue write quiet", 1'b0, 18'h0);
      rd(6'd1);
      expect_out("R7/R9 write went to latched address", 1'b1, refm[1]);
      rd(6'd9);
      expect_out("R7 stray address untouched", 1'b1, refm[9]);
      des();
   endtask

   task automatic t_write_kill();
      pipe_mode = 1'b1;
      des(); des();
      rd(6'd2);
      expect_out("R3 read in flight", 1'b0, 18'h0);
      wr(6'd6, 18'h15A5A);
      expect_out("R8 pending read dropped", 1'b0, 18'h0);
      des();
      expect_out("R8 write never reaches bus", 1'b0, 18'h0);
      rd(6'd6);
      des();
      expect_out("R9 readback", 1'b1, 18'h15A5A);
      des();
   endtask

   task automatic t_sleep();
      pipe_mode = 1'b0;
      des();
      sleep_req = 1'b1;
      rd(6'd0);
      expect_out("R10 still awake", 1'b1, refm[0]);
      rd(6'd0);
      expect_out("R10 asleep", 1'b0, 18'h0);
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 6'd0, 18'h3FFFF);
      expect_out("R10 write ignored", 1'b0, 18'h0);
      sleep_req = 1'b0;
      rd(6'd0);
      expect_out("R10 wake not yet", 1'b0, 18'h0);
      des();
      rd(6'd0);
      expect_out("R10 contents kept", 1'b1, refm[0]);
      des();
   endtask

   initial begin
      t_reset();
      t_fill();
      t_flow();
      t_pipe();
      t_pipe_stream();
      t_oe();
      t_select();
      t_continue();
      t_write_kill();
      t_sleep();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule